// File: doc/BRIEF.md
# Flash Block Lock Controller

This block keeps the write-protection state of every erase block in a 4M-word flash array. The array is split into two banks. In the default bottom-boot arrangement, the low bank begins with eight 4K-word parameter blocks, followed by thirty-one 32K-word blocks. The high bank holds ninety-six 32K-word blocks. In total there are 135 blocks. Each block is in one of three states: unlocked, locked, or locked-down.

The host writes two-cycle lock commands that have already been decoded. Each write carries a data byte and a word address. The first cycle is the prefix `60h`. The second cycle carries the operation code and an address anywhere inside the target block. The block turns the address into a block index and updates that one block.

A query port returns the lock bits of the block that holds any address. A program/erase check port either grants or refuses a request. A refused request raises a lock-error pulse, which is meant to be bit 1 of a status word. The reset pin returns every block to locked. The write-protect pin decides whether locked-down blocks may still be changed.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After `rst_n` is released, every block reads locked: `qry_locked`=1 and `qry_lockdown`=0 at any queried address.
- R2: With `TOP_BOOT`=0, the 32K-word range at address 0 is split into eight 4K-word blocks, each changed independently. Every other block spans the 32K words that share `addr[21:15]`, including across the bank edge at word 0x100000.
- R3: A write of `60h` followed by a later write of `D0h` unlocks the addressed block. `60h` followed by `01h` locks it. Idle cycles between the two writes are allowed.
- R4: `60h` followed by `2Fh` puts the addressed block in locked-down, whatever the level of `wp_n`. A locked-down block reads `qry_locked`=1 and `qry_lockdown`=1.
- R5: While `wp_n` is 0, an unlock or lock command to a locked-down block has no effect, and the block stays locked-down.
- R6: While `wp_n` is 1, a locked-down block behaves as plain locked. Unlock moves it to unlocked (both bits 0), and lock moves it to locked (`qry_lockdown`=0).
- R7: If the second write after `60h` is any value other than `01h`, `D0h` or `2Fh`, the sequence is dropped with no state change. The next write is taken as a first cycle. A first write other than `60h` is ignored.
- R8: `pe_ok` equals `pe_req` when the block holding `pe_addr` is unlocked. `pe_ok` is 0 otherwise. A refused request drives `lock_err` high for exactly the following cycle.
- R9: One clock with `rp_n`=0 returns every block to locked with the lock-down bit cleared, and cancels a pending `60h` prefix.
- R10: With `TOP_BOOT`=1, the eight 4K-word blocks sit in the top 32K words (0x3F8000–0x3FFFFF). The 32K-word block just below them is separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_n | input | 1 | Device reset pin, active low, sampled on the clock |
| wp_n | input | 1 | Write-protect pin; 0 makes the locked-down state binding |
| cmd_valid | input | 1 | A command write is present this cycle |
| cmd_data | input | 8 | Command byte |
| cmd_addr | input | ADDR_W | Word address of the command write |
| qry_addr | input | ADDR_W | Address whose block state is queried |
| qry_locked | output | 1 | Lock bit of the queried block |
| qry_lockdown | output | 1 | Lock-down bit of the queried block |
| pe_req | input | 1 | Program/erase request |
| pe_addr | input | ADDR_W | Target address of the request |
| pe_ok | output | 1 | Request allowed |
| lock_err | output | 1 | One-cycle pulse after a refused request |

## Verification
The hardest case to reach from the ports is a locked-down block that receives unlock and lock commands while `wp_n` is low. The block must first be driven into locked-down through a complete prefix-plus-`2Fh` sequence. Then `wp_n` is lowered, and the same block is hit with full unlock and lock sequences at a different address inside it. Its state is read back through the query port after each sequence. The bench then raises `wp_n` and repeats the sequences to show that the override takes effect. A prefix left pending across an `rp_n` pulse is also covered: the bench writes `60h`, pulses reset, and then writes `D0h`, which must not unlock anything.

// File: rtl/flk_pkg.sv
package flk_pkg;

   localparam logic [7:0] CMD_PREFIX = 8'h60;
   localparam logic [7:0] CMD_LOCK   = 8'h01;
   localparam logic [7:0] CMD_UNLOCK = 8'hD0;
   localparam logic [7:0] CMD_DOWN   = 8'h2F;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_LOCK   = 2'd1,
      OP_UNLOCK = 2'd2,
      OP_DOWN   = 2'd3
   } lk_op_t;

   typedef struct packed {
      logic dn;
      logic lk;
   } blk_st_t;

   localparam blk_st_t ST_LOCKED = '{dn: 1'b0, lk: 1'b1};

   // next state of one block for one operation
   function automatic blk_st_t blk_next(blk_st_t cur, lk_op_t op, logic wp_n);
      blk_st_t nxt;
      nxt = cur;
      case (op)
         OP_LOCK:   if (!(cur.dn && !wp_n)) nxt = '{dn: 1'b0, lk: 1'b1};
         OP_UNLOCK: if (!(cur.dn && !wp_n)) nxt = '{dn: 1'b0, lk: 1'b0};
         OP_DOWN:   nxt = '{dn: 1'b1, lk: 1'b1};
         default:   nxt = cur;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/flk_addr_map.sv
module flk_addr_map #(
   parameter int ADDR_W    = 22,
   parameter int MAIN_LOG2 = 15,
   parameter int PAR_LOG2  = 12,
   parameter bit TOP_BOOT  = 1'b0,
   parameter int IDX_W     = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int SLOT_W = ADDR_W - MAIN_LOG2;
   localparam int SUB_W  = MAIN_LOG2 - PAR_LOG2;
   localparam int NSLOT  = 2 ** SLOT_W;
   localparam int NPAR   = 2 ** SUB_W;

   logic [SLOT_W-1:0] slot;
   logic [SUB_W-1:0]  sub;
   logic              unused_lo;

   assign slot      = addr[ADDR_W-1:MAIN_LOG2];
   assign sub       = addr[MAIN_LOG2-1:PAR_LOG2];
   assign unused_lo = ^addr[PAR_LOG2-1:0];

   generate
      if (TOP_BOOT) begin : g_top
         // main blocks take indices 0..NSLOT-2, small blocks follow
         always_comb begin
            if (slot == SLOT_W'(NSLOT - 1))
               idx = IDX_W'(NSLOT - 1) + IDX_W'(sub);
            else
               idx = IDX_W'(slot);
         end
      end else begin : g_bot
         // small blocks take indices 0..NPAR-1, main blocks follow
         always_comb begin
            if (slot == '0)
               idx = IDX_W'(sub);
            else
               idx = IDX_W'(slot) + IDX_W'(NPAR - 1);
         end
      end
   endgenerate
endmodule

// File: rtl/flk_cmd_seq.sv
module flk_cmd_seq
   import flk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rp_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   output logic       armed,
   output lk_op_t     op
);
   // second-cycle decode
   always_comb begin
      op = OP_NONE;
      if (armed && cmd_valid) begin
         case (cmd_data)
            CMD_LOCK:   op = OP_LOCK;
            CMD_UNLOCK: op = OP_UNLOCK;
            CMD_DOWN:   op = OP_DOWN;
            default:    op = OP_NONE;
         endcase
      end
   end

   // prefix tracking: any write while armed closes the sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (!rp_n)
         armed <= 1'b0;
      else if (cmd_valid)
         armed <= !armed && (cmd_data == CMD_PREFIX);
   end
endmodule

// File: rtl/flk_state_array.sv
module flk_state_array
   import flk_pkg::*;
#(
   parameter int NBLK  = 135,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rp_n,
   input  logic             wp_n,
   input  lk_op_t           op,
   input  logic [IDX_W-1:0] upd_idx,
   output logic [NBLK-1:0]  lk_vec,
   output logic [NBLK-1:0]  dn_vec
);
   generate
      for (genvar b = 0; b < NBLK; b++) begin : g_blk
         blk_st_t st_q;
         logic    hit;

         assign hit = (op != OP_NONE) && (upd_idx == IDX_W'(b));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               st_q <= ST_LOCKED;
            else if (!rp_n)
               st_q <= ST_LOCKED;
            else if (hit)
               st_q <= blk_next(st_q, op, wp_n);
         end

         assign lk_vec[b] = st_q.lk;
         assign dn_vec[b] = st_q.dn;
      end
   endgenerate
endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
   import flk_pkg::*;
#(
   parameter int ADDR_W     = 22,
   parameter int MAIN_LOG2  = 15,
   parameter int PAR_LOG2   = 12,
   parameter int BANKA_MAIN = 31,
   parameter int BANKB_MAIN = 96,
   parameter bit TOP_BOOT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rp_n,
   input  logic              wp_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_data,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] qry_addr,
   output logic              qry_locked,
   output logic              qry_lockdown,
   input  logic              pe_req,
   input  logic [ADDR_W-1:0] pe_addr,
   output logic              pe_ok,
   output logic              lock_err
);
   localparam int NSLOT = 2 ** (ADDR_W - MAIN_LOG2);
   localparam int NPAR  = 2 ** (MAIN_LOG2 - PAR_LOG2);
   localparam int NBLK  = NPAR + NSLOT - 1;
   localparam int IDX_W = $clog2(NBLK);

   // elaboration checks on the geometry
   generate
      if (MAIN_LOG2 <= PAR_LOG2 || ADDR_W <= MAIN_LOG2) begin : g_bad_sizes
         $error("flk_lock_ctrl: block size parameters out of order");
      end
      if (BANKA_MAIN + 1 + BANKB_MAIN != NSLOT) begin : g_bad_banks
         $error("flk_lock_ctrl: bank block counts do not fill the address space");
      end
   endgenerate

   logic             armed;
   lk_op_t           op;
   logic [IDX_W-1:0] cmd_idx, qry_idx, pe_idx;
   logic [NBLK-1:0]  lk_vec, dn_vec;
   logic             pe_locked;

   flk_cmd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rp_n      (rp_n),
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .armed     (armed),
      .op        (op)
   );

   flk_addr_map #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PAR_LOG2(PAR_LOG2),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
   u_map_cmd (.addr(cmd_addr), .idx(cmd_idx));

   flk_addr_map #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PAR_LOG2(PAR_LOG2),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
   u_map_qry (.addr(qry_addr), .idx(qry_idx));

   flk_addr_map #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PAR_LOG2(PAR_LOG2),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
   u_map_pe (.addr(pe_addr), .idx(pe_idx));

   flk_state_array #(.NBLK(NBLK), .IDX_W(IDX_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rp_n    (rp_n),
      .wp_n    (wp_n),
      .op      (op),
      .upd_idx (cmd_idx),
      .lk_vec  (lk_vec),
      .dn_vec  (dn_vec)
   );

   assign qry_locked   = lk_vec[qry_idx];
   assign qry_lockdown = dn_vec[qry_idx];
   assign pe_locked    = lk_vec[pe_idx];
   assign pe_ok        = pe_req && !pe_locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_err <= 1'b0;
      else if (!rp_n)
         lock_err <= 1'b0;
      else
         lock_err <= pe_req && pe_locked;
   end
endmodule

// File: rtl/flk_lock_ctrl_chk.sv
module flk_lock_ctrl_chk
   import flk_pkg::*;
#(
   parameter int ADDR_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rp_n,
   input logic              wp_n,
   input logic              cmd_valid,
   input logic [7:0]        cmd_data,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [ADDR_W-1:0] qry_addr,
   input logic              qry_locked,
   input logic              qry_lockdown,
   input logic              pe_req,
   input logic              pe_ok,
   input logic              lock_err,
   input logic              armed
);
   p_rp_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rp_n) |-> (qry_locked && !qry_lockdown));

   p_down_has_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      qry_lockdown |-> qry_locked);

   p_down_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed && cmd_valid && cmd_data == CMD_DOWN && rp_n)
       && qry_addr == $past(cmd_addr)) |-> qry_lockdown);

   p_wp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed && cmd_valid && rp_n && !wp_n && qry_lockdown
             && (cmd_data == CMD_UNLOCK || cmd_data == CMD_LOCK)
             && qry_addr == cmd_addr)
       && $stable(qry_addr)) |-> qry_lockdown);

   p_prefix_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_valid && !armed && cmd_data == CMD_PREFIX && rp_n) |-> armed);

   p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pe_ok |-> pe_req);

   p_err_after_refusal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> $past(pe_req && !pe_ok && rp_n));
endmodule

bind flk_lock_ctrl flk_lock_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rp_n         (rp_n),
   .wp_n         (wp_n),
   .cmd_valid    (cmd_valid),
   .cmd_data     (cmd_data),
   .cmd_addr     (cmd_addr),
   .qry_addr     (qry_addr),
   .qry_locked   (qry_locked),
   .qry_lockdown (qry_lockdown),
   .pe_req       (pe_req),
   .pe_ok        (pe_ok),
   .lock_err     (lock_err),
   .armed        (armed)
);

// File: tb/flk_lock_ctrl_tb_top.sv
module flk_lock_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rp_n = 1'b1;
   logic          wp_n = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_data = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [AW-1:0] qry_addr = '0;
   logic          pe_req = 1'b0;
   logic [AW-1:0] pe_addr = '0;
   logic          b_lk, b_dn, b_ok, b_err;
   logic          t_lk, t_dn, t_ok, t_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flk_lock_ctrl #(.TOP_BOOT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
      .qry_addr(qry_addr), .qry_locked(b_lk), .qry_lockdown(b_dn),
      .pe_req(pe_req), .pe_addr(pe_addr), .pe_ok(b_ok), .lock_err(b_err));

   flk_lock_ctrl #(.TOP_BOOT(1'b1)) dut_top_i (
      .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
      .qry_addr(qry_addr), .qry_locked(t_lk), .qry_lockdown(t_dn),
      .pe_req(pe_req), .pe_addr(pe_addr), .pe_ok(t_ok), .lock_err(t_err));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d, logic [AW-1:0] a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = d; cmd_addr = a;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // query the bottom-boot instance: {locked, lockdown}
   task automatic qb(logic [AW-1:0] a, logic [1:0] exp, string req);
      qry_addr = a; #1;
      chk(req, {30'd0, b_lk, b_dn}, {30'd0, exp});
   endtask

   task automatic qt(logic [AW-1:0] a, logic [1:0] exp, string req);
      qry_addr = a; #1;
      chk(req, {30'd0, t_lk, t_dn}, {30'd0, exp});
   endtask

   // program/erase check on the bottom-boot instance
   task automatic pe_try(logic [AW-1:0] a, logic exp_ok, string req);
      @(negedge clk);
      pe_req = 1'b1; pe_addr = a; #1;
      chk(req, {31'd0, b_ok}, {31'd0, exp_ok});
      @(negedge clk);
      pe_req = 1'b0; #1;
      chk(req, {31'd0, b_err}, {31'd0, !exp_ok});
      @(negedge clk); #1;
      chk(req, {31'd0, b_err}, 32'd0);
   endtask

   task automatic t_reset;
      qb(22'h000000, 2'b10, "R1 bottom small block");
      qb(22'h2ABCDE, 2'b10, "R1 bank B block");
      qt(22'h3FFFFF, 2'b10, "R1 top instance");
      pe_try(22'h000123, 1'b0, "R8 refuse after reset");
   endtask

   task automatic t_small_blocks;
      wr(8'h60, 22'h001234); wr(8'hD0, 22'h001234);
      qb(22'h001000, 2'b00, "R3 unlock small block");
      qb(22'h001FFF, 2'b00, "R2 small block upper edge");
      qb(22'h000FFF, 2'b10, "R2 lower neighbour untouched");
      qb(22'h002000, 2'b10, "R2 upper neighbour untouched");
      pe_try(22'h001ABC, 1'b1, "R8 grant on unlocked");
   endtask

   task automatic t_bank_edge;
      wr(8'h60, 22'h0F8123); wr(8'hD0, 22'h0F8123);
      qb(22'h0FFFFF, 2'b00, "R2 last low-bank block");
      qb(22'h100000, 2'b10, "R2 first high-bank block");
      qb(22'h0F7FFF, 2'b10, "R2 block below");
      wr(8'h60, 22'h0F8000); wr(8'h01, 22'h0FC000);
      qb(22'h0F8000, 2'b10, "R3 relock");
   endtask

   task automatic t_lockdown;
      wp_n = 1'b0;
      wr(8'h60, 22'h200040); wr(8'h2F, 22'h200040);
      qb(22'h207FFF, 2'b11, "R4 lock-down set");
      wr(8'h60, 22'h204000); wr(8'hD0, 22'h204000);
      qb(22'h200000, 2'b11, "R5 unlock ignored");
      wr(8'h60, 22'h204000); wr(8'h01, 22'h204000);
      qb(22'h200000, 2'b11, "R5 lock ignored");
      pe_try(22'h203000, 1'b0, "R8 refuse locked-down");
   endtask

   task automatic t_wp_override;
      wp_n = 1'b1;
      wr(8'h60, 22'h200000); wr(8'hD0, 22'h200000);
      qb(22'h200000, 2'b00, "R6 unlock with wp high");
      wr(8'h60, 22'h200000); wr(8'h2F, 22'h200000);
      qb(22'h200000, 2'b11, "R4 lock-down with wp high");
      wr(8'h60, 22'h200000); wr(8'h01, 22'h200000);
      qb(22'h200000, 2'b10, "R6 lock clears lock-down");
   endtask

   task automatic t_abandon;
      wr(8'h60, 22'h300000); wr(8'h55, 22'h300000);
      wr(8'hD0, 22'h300000);
      qb(22'h300000, 2'b10, "R7 bad second byte drops sequence");
      wr(8'h70, 22'h300000); wr(8'hD0, 22'h300000);
      qb(22'h300000, 2'b10, "R7 non-prefix first byte ignored");
      wr(8'h60, 22'h300000);
      @(negedge clk); @(negedge clk);
      wr(8'hD0, 22'h300000);
      qb(22'h300000, 2'b00, "R3 idle cycles between writes");
   endtask

   task automatic t_rp;
      wr(8'h60, 22'h150000); wr(8'h2F, 22'h150000);
      @(negedge clk); rp_n = 1'b0;
      @(negedge clk); rp_n = 1'b1;
      qb(22'h150000, 2'b10, "R9 lock-down cleared");
      qb(22'h300000, 2'b10, "R9 unlocked block relocked");
      qb(22'h001000, 2'b10, "R9 small block relocked");
      wr(8'h60, 22'h050000);
      @(negedge clk); rp_n = 1'b0;
      @(negedge clk); rp_n = 1'b1;
      wr(8'hD0, 22'h050000);
      qb(22'h050000, 2'b10, "R9 pending prefix cancelled");
   endtask

   task automatic t_top_boot;
      wr(8'h60, 22'h3F9000); wr(8'hD0, 22'h3F9000);
      qt(22'h3F9FFF, 2'b00, "R10 top small block unlocked");
      qt(22'h3FA000, 2'b10, "R10 upper neighbour");
      qt(22'h3F8FFF, 2'b10, "R10 lower neighbour");
      qt(22'h3F7FFF, 2'b10, "R10 main block below separate");
      qb(22'h3FA000, 2'b00, "R2 same range is one block in bottom boot");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_blocks();
      t_bank_edge();
      t_lockdown();
      t_wp_override();
      t_abandon();
      t_rp();
      t_top_boot();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule